// File: doc/BRIEF.md
# Serial SAR Converter Conversion Sequencer

This block is the host-side master for a small serial successive-approximation converter. It runs exactly one conversion per request. The converter has no command word. The request's select bit instead picks the input channel (or unipolar/bipolar format) through the shape of the conversion-start line. A plain single rise selects the first choice. A short high, short low, then high again selects the second.

After the start line has risen for the last time, the sequencer holds it high for the acquisition window and then drops it. It waits out the converter's internal conversion time. It then clocks the serial frame in with an idle-low clock, sampling on the rising edge. Finally it returns the 10-bit result together with a one-cycle valid strobe.

Each delay is a count of system-clock cycles derived from a nanosecond parameter. A per-request flag picks between two read styles:
- a single 12-clock read;
- a read split into two 8-clock bytes separated by a short gap.

Top module: `convSequencer`

## Requirements
- R1: A request (reqValid high) is taken only on a clock edge where reqReady is 1. While busy, the values on reqValid, reqSel and reqSplit are ignored. reqReady goes to 0 on the edge that takes a request, stays 0 through the strobe cycle, and returns to 1 one cycle later.
- R2: With reqSel=0, convStart rises on the edge that takes the request. With reqSel=1, convStart is high for PULSE_CYC cycles, then low for PULSE_CYC cycles, and then rises again.
- R3: After its final rise, convStart stays high for exactly ACQ_CYC cycles before falling.
- R4: After convStart falls, sclk stays low for CONV_CYC + HALF_CYC cycles before its first rise.
- R5: sclk idles low and is never high while convStart is high. Every sclk high phase and every sclk low phase inside a frame lasts HALF_CYC cycles.
- R6: With reqSplit=0 the frame has exactly 12 sclk rises. With reqSplit=1 it has exactly 16, and GAP_CYC extra low cycles are inserted between the 8th and 9th rise.
- R7: sdi is sampled on the system-clock edge on which sclk rises, most significant bit first. resData is the first 10 bits received. The bits after them (2 sub-bits, or 6 in split mode) do not affect resData.
- R8: resValid is high for one cycle: the cycle in which sclk shows its last fall. resData changes on that edge and holds until the next strobe.
- R9: Each delay count is ceil(ns × CLK_MHZ / 1000), with a floor of 1. At the defaults (200 MHz; 30, 1400, 3700, 63 and 125 ns) this gives PULSE_CYC=6, ACQ_CYC=280, CONV_CYC=740, HALF_CYC=13 and GAP_CYC=25.
- R10: During and just after reset, convStart, sclk and resValid are 0, reqReady is 1 and resData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Conversion request |
| reqSel | input | 1 | 0: single-rise start; 1: double-pulse start |
| reqSplit | input | 1 | 0: 12-clock read; 1: two 8-clock bytes |
| reqReady | output | 1 | Sequencer idle, request may be taken |
| convStart | output | 1 | Conversion-start line to the converter |
| sclk | output | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from the converter |
| resValid | output | 1 | One-cycle result strobe |
| resData | output | RES_BITS | Conversion result |

## Verification
The embedded assertions check timing properties on every cycle:
- minimum start-line pulse width and acquisition length;
- the wait between the start line falling and the first serial edge;
- minimum clock phase widths;
- the clock staying low while the start line is high;
- idle quiet outputs, the single-cycle strobe;
- the rise count per frame in each read style.

Other behaviours can only be shown by the bench's scenarios. These are the exact cycle of every transition, the bit order and the discarding of sub-bits and trailing bits, requests held high while busy with changing select values, and the result holding between strobes. The bench's cycle model and its converter model cover these.

// File: rtl/convSeqPkg.sv
`timescale 1ns/1ps
package convSeqPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_HI,
    ST_PRE_LO,
    ST_ACQ,
    ST_CONV,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_GAP,
    ST_DONE
  } seqState_e;

  // Strobes from the control FSM to the capture datapath
  typedef struct packed {
    logic load;     // request taken: clear frame, latch read style
    logic shift;    // sclk rises on this edge: capture sdi
    logic publish;  // frame complete: move result to output
  } dpStrobe_t;

  // Round a duration in ns up to whole system-clock cycles, at least one
  function automatic int nsToCycles(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/convSeqCtrl.sv
`timescale 1ns/1ps
module convSeqCtrl
  import convSeqPkg::*;
#(
  parameter int PULSE_CYC = 6,
  parameter int ACQ_CYC   = 280,
  parameter int CONV_CYC  = 740,
  parameter int HALF_CYC  = 13,
  parameter int GAP_CYC   = 25,
  parameter int CNT_W     = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqSel,
  input  logic      lastBit,
  input  logic      byteEnd,
  output dpStrobe_t strobe,
  output logic      reqReady,
  output logic      convStart,
  output logic      sclk,
  output logic      resValid
);

  localparam logic [CNT_W-1:0] PULSE_M1 = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] ACQ_M1   = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_M1  = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_M1  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_M1   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] SAT      = '1;

  seqState_e        state, stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic             expire;

  assign expire = (waitCnt == '0);

  // Remaining-cycle load value for the state being entered
  function automatic logic [CNT_W-1:0] loadFor(input seqState_e s);
    case (s)
      ST_PRE_HI, ST_PRE_LO: return PULSE_M1;
      ST_ACQ:               return ACQ_M1;
      ST_CONV:              return CONV_M1;
      ST_CLK_LO, ST_CLK_HI: return HALF_M1;
      ST_GAP:               return GAP_M1;
      default:              return '0;
    endcase
  endfunction

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNext   = reqSel ? ST_PRE_HI : ST_ACQ;
          strobe.load = 1'b1;
        end
      end
      ST_PRE_HI: if (expire) stateNext = ST_PRE_LO;
      ST_PRE_LO: if (expire) stateNext = ST_ACQ;
      ST_ACQ:    if (expire) stateNext = ST_CONV;
      ST_CONV:   if (expire) stateNext = ST_CLK_LO;
      ST_CLK_LO: begin
        if (expire) begin
          stateNext    = ST_CLK_HI;
          strobe.shift = 1'b1;
        end
      end
      ST_CLK_HI: begin
        if (expire) begin
          if (lastBit) begin
            stateNext      = ST_DONE;
            strobe.publish = 1'b1;
          end else if (byteEnd) begin
            stateNext = ST_GAP;
          end else begin
            stateNext = ST_CLK_LO;
          end
        end
      end
      ST_GAP:  if (expire) stateNext = ST_CLK_LO;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  // Pins are registered from the next state so they move with it, glitch-free
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      reqReady  <= 1'b1;
      convStart <= 1'b0;
      sclk      <= 1'b0;
      resValid  <= 1'b0;
    end else begin
      state <= stateNext;
      if (stateNext != state) waitCnt <= loadFor(stateNext);
      else if (!expire)       waitCnt <= waitCnt - 1'b1;
      reqReady  <= (stateNext == ST_IDLE);
      convStart <= (stateNext == ST_PRE_HI) || (stateNext == ST_ACQ);
      sclk      <= (stateNext == ST_CLK_HI);
      resValid  <= (stateNext == ST_DONE);
    end
  end

  // ---------------- run-length monitors for the timing assertions
  logic [CNT_W-1:0] csHighRun, csLowRun, sckHighRun, sckLowRun;
  logic             sawClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csHighRun  <= '0;
      csLowRun   <= '0;
      sckHighRun <= '0;
      sckLowRun  <= '0;
      sawClk     <= 1'b0;
    end else begin
      csHighRun  <= convStart ? ((csHighRun == SAT) ? SAT : csHighRun + 1'b1) : '0;
      csLowRun   <= !convStart ? ((csLowRun == SAT) ? SAT : csLowRun + 1'b1) : '0;
      sckHighRun <= sclk ? ((sckHighRun == SAT) ? SAT : sckHighRun + 1'b1) : '0;
      sckLowRun  <= !sclk ? ((sckLowRun == SAT) ? SAT : sckLowRun + 1'b1) : '0;
      sawClk     <= convStart ? 1'b0 : (sclk ? 1'b1 : sawClk);
    end
  end

  assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!convStart && !sclk && !resValid));

  assert_take_drops_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convStart) |-> (csHighRun >= CNT_W'(PULSE_CYC)));

  assert_acq_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(convStart) && state == ST_CONV) |-> (csHighRun >= CNT_W'(ACQ_CYC)));

  assert_conv_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclk) && !sawClk) |-> (csLowRun >= CNT_W'(CONV_CYC)));

  assert_sclk_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> (sckHighRun >= CNT_W'(HALF_CYC)));

  assert_sclk_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> (sckLowRun >= CNT_W'(HALF_CYC)));

  assert_sclk_while_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !sclk);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> (!resValid && reqReady));

endmodule

// File: rtl/convSeqDatapath.sv
`timescale 1ns/1ps
module convSeqDatapath
  import convSeqPkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int SUB_BITS  = 2,
  parameter int BYTE_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                reqSplit,
  input  logic                sdi,
  output logic                lastBit,
  output logic                byteEnd,
  output logic [RES_BITS-1:0] resData
);

  localparam int FRAME_STD   = RES_BITS + SUB_BITS;
  localparam int FRAME_SPLIT = 2 * BYTE_BITS;
  localparam int FRAME_MAX   = maxOf(FRAME_STD, FRAME_SPLIT);
  localparam int BIT_W       = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] shreg;
  logic [BIT_W-1:0]     bitCnt;
  logic [BIT_W-1:0]     frameLen;
  logic                 splitQ;
  logic [RES_BITS-1:0]  headStd, headSplit;

  assign frameLen  = splitQ ? BIT_W'(FRAME_SPLIT) : BIT_W'(FRAME_STD);
  assign lastBit   = (bitCnt == frameLen);
  assign byteEnd   = splitQ && (bitCnt == BIT_W'(BYTE_BITS));
  // The first bits received sit at the top of the frame, MSB first
  assign headStd   = shreg[FRAME_STD-1 -: RES_BITS];
  assign headSplit = shreg[FRAME_SPLIT-1 -: RES_BITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg   <= '0;
      bitCnt  <= '0;
      splitQ  <= 1'b0;
      resData <= '0;
    end else begin
      if (strobe.load) begin
        shreg  <= '0;
        bitCnt <= '0;
        splitQ <= reqSplit;
      end else if (strobe.shift) begin
        shreg  <= {shreg[FRAME_MAX-2:0], sdi};
        bitCnt <= bitCnt + 1'b1;
      end
      if (strobe.publish) resData <= splitQ ? headSplit : headStd;
    end
  end

  assert_no_extra_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> (bitCnt < frameLen));

  assert_publish_complete_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |-> !strobe.shift);

endmodule

// File: rtl/convSequencer.sv
`timescale 1ns/1ps
module convSequencer
  import convSeqPkg::*;
#(
  parameter int CLK_MHZ      = 200,
  parameter int RES_BITS     = 10,
  parameter int SUB_BITS     = 2,
  parameter int BYTE_BITS    = 8,
  parameter int PULSE_NS     = 30,
  parameter int ACQ_NS       = 1400,
  parameter int CONV_NS      = 3700,
  parameter int SCLK_HALF_NS = 63,
  parameter int BYTE_GAP_NS  = 125
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqSel,
  input  logic                reqSplit,
  output logic                reqReady,
  output logic                convStart,
  output logic                sclk,
  input  logic                sdi,
  output logic                resValid,
  output logic [RES_BITS-1:0] resData
);

  localparam int PULSE_CYC = nsToCycles(PULSE_NS, CLK_MHZ);
  localparam int ACQ_CYC   = nsToCycles(ACQ_NS, CLK_MHZ);
  localparam int CONV_CYC  = nsToCycles(CONV_NS, CLK_MHZ);
  localparam int HALF_CYC  = nsToCycles(SCLK_HALF_NS, CLK_MHZ);
  localparam int GAP_CYC   = nsToCycles(BYTE_GAP_NS, CLK_MHZ);
  localparam int MAX_CYC   = maxOf(maxOf(maxOf(PULSE_CYC, ACQ_CYC), maxOf(CONV_CYC, HALF_CYC)), GAP_CYC);
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam int FRAME_STD   = RES_BITS + SUB_BITS;
  localparam int FRAME_SPLIT = 2 * BYTE_BITS;
  localparam int EDGE_W    = $clog2(maxOf(FRAME_STD, FRAME_SPLIT) + 2);

  dpStrobe_t strobe;
  logic      lastBit, byteEnd;

  convSeqCtrl #(
    .PULSE_CYC(PULSE_CYC), .ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC),
    .HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel),
    .lastBit(lastBit), .byteEnd(byteEnd), .strobe(strobe),
    .reqReady(reqReady), .convStart(convStart), .sclk(sclk), .resValid(resValid)
  );

  convSeqDatapath #(
    .RES_BITS(RES_BITS), .SUB_BITS(SUB_BITS), .BYTE_BITS(BYTE_BITS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqSplit(reqSplit), .sdi(sdi),
    .lastBit(lastBit), .byteEnd(byteEnd), .resData(resData)
  );

  // ---------------- rise count per frame, seen at the pins
  logic [EDGE_W-1:0] edgeCount;
  logic              splitSeen, sclkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCount <= '0;
      splitSeen <= 1'b0;
      sclkPrev  <= 1'b0;
    end else begin
      sclkPrev <= sclk;
      if (reqValid && reqReady) begin
        edgeCount <= '0;
        splitSeen <= reqSplit;
      end else if (sclk && !sclkPrev) begin
        edgeCount <= edgeCount + 1'b1;
      end
    end
  end

  assert_frame_edges_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> (edgeCount == (splitSeen ? EDGE_W'(FRAME_SPLIT) : EDGE_W'(FRAME_STD))));

endmodule

// File: tb/sim_convSequencer.sv
`timescale 1ns/1ps
module sim_convSequencer;

  // Cycle counts from R9 at 200 MHz: ceil(ns*200/1000)
  localparam int PULSE_C = (30 * 200 + 999) / 1000;    // 6
  localparam int ACQ_C   = (1400 * 200 + 999) / 1000;  // 280
  localparam int CONV_C  = (3700 * 200 + 999) / 1000;  // 740
  localparam int HALF_C  = (63 * 200 + 999) / 1000;    // 13
  localparam int GAP_C   = (125 * 200 + 999) / 1000;   // 25
  localparam int MAX_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqSel = 1'b0, reqSplit = 1'b0;
  logic       reqReady, convStart, sclk, resValid;
  logic       sdi = 1'b0;
  logic [9:0] resData;

  always #2.5 clk = ~clk;

  convSequencer u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel), .reqSplit(reqSplit),
    .reqReady(reqReady), .convStart(convStart), .sclk(sclk), .sdi(sdi),
    .resValid(resValid), .resData(resData)
  );

  int nCmp = 0, nBad = 0;
  bit finished = 0;
  bit comparing = 0;

  // ---------------- behavioural cycle model: a queue of expected pin states
  typedef struct {
    bit cs; bit sck; bit rdy; bit vld; int tag;
  } expCyc_t;

  expCyc_t    expQ[$];
  expCyc_t    cur = '{0, 0, 1, 0, 1};
  logic [15:0] pendFrame = '0;     // frame the stimulus offers
  logic [15:0] takenFrame = '0;    // frame of the request the model took
  logic [9:0]  lastData = '0;

  task automatic pushN(bit cs, bit sck, bit vld, int tag, int n);
    for (int i = 0; i < n; i++) expQ.push_back('{cs, sck, 1'b0, vld, tag});
  endtask

  task automatic buildSeq(bit sel, bit split);
    int frame;
    if (sel) begin                        // R2 double pulse
      pushN(1, 0, 0, 2, PULSE_C);
      pushN(0, 0, 0, 2, PULSE_C);
    end
    pushN(1, 0, 0, 3, ACQ_C);             // R3 acquisition
    pushN(0, 0, 0, 4, CONV_C);            // R4 conversion wait
    frame = split ? 16 : 12;              // R6 rise count
    for (int b = 0; b < frame; b++) begin
      if (split && b == 8) pushN(0, 0, 0, 6, GAP_C);
      pushN(0, 0, 0, 5, HALF_C);          // R5 phases
      pushN(0, 1, 0, 5, HALF_C);
    end
    pushN(0, 0, 1, 8, 1);                 // R8 strobe
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      expQ.delete();
      cur      = '{0, 0, 1, 0, 10};
      lastData = '0;
    end else begin
      if (cur.rdy && reqValid) begin      // R1 take only when ready
        buildSeq(reqSel, reqSplit);
        takenFrame = pendFrame;
      end
      if (expQ.size() > 0) cur = expQ.pop_front();
      else cur = '{0, 0, 1, 0, 1};
      if (cur.vld) lastData = takenFrame[15:6];   // R7 first ten bits
    end
  end

  // ---------------- converter model: MSB first, next bit on each sclk fall
  logic [15:0] liveFrame = '0;
  int ptr = 0;
  always @(posedge convStart) liveFrame = takenFrame;
  always @(negedge convStart) begin ptr = 15; sdi = liveFrame[15]; end
  always @(negedge sclk) begin
    ptr = ptr - 1;
    sdi = (ptr >= 0) ? liveFrame[ptr] : 1'b0;
  end

  // ---------------- compare on every falling edge
  always @(negedge clk) begin
    if (comparing && !finished) begin
      nCmp++;
      if (convStart !== cur.cs || sclk !== cur.sck || reqReady !== cur.rdy ||
          resValid !== cur.vld) begin
        nBad++;
        $display("FAIL R%0d t=%0t: cs/sclk/rdy/vld=%b%b%b%b expected %b%b%b%b", cur.tag, $time,
                 convStart, sclk, reqReady, resValid, cur.cs, cur.sck, cur.rdy, cur.vld);
      end
      if (resData !== lastData) begin     // R7 value, R8 hold
        nBad++;
        $display("FAIL %s t=%0t: resData=%h expected %h", cur.vld ? "R7" : "R8", $time,
                 resData, lastData);
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  // Caller sits at a falling edge; returns at the falling edge after the take
  task automatic doReq(bit sel, bit split, logic [9:0] data, logic [5:0] tail);
    reqValid  = 1'b1;
    reqSel    = sel;
    reqSplit  = split;
    pendFrame = {data, tail};
    while (!reqReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    reqValid = 1'b0;
    @(negedge clk);
    while (expQ.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    nCmp++;
    if (convStart !== 1'b0 || sclk !== 1'b0 || resValid !== 1'b0 || reqReady !== 1'b1 ||
        resData !== 10'h0) begin
      nBad++;
      $display("FAIL R10: cs/sclk/vld/rdy=%b%b%b%b data=%h expected 0001 000", convStart, sclk,
               resValid, reqReady, resData);
    end
    rstN = 1'b1;
    comparing = 1;
    @(negedge clk);
    // R2 single rise, R6 12 clocks, R7 sub-bits set to ones are dropped
    doReq(0, 0, 10'h2A5, 6'b111111);
    drain();
    // R2 double pulse, R7 all-zero result with ones after it
    doReq(1, 0, 10'h000, 6'b111111);
    drain();
    // R6 split read with gap, R7 full-scale with zeros after it
    doReq(0, 1, 10'h3FF, 6'b000000);
    drain();
    // R6 split with double pulse, R7 trailing pattern ignored
    doReq(1, 1, 10'h155, 6'b101010);
    drain();
    // R1 request held high through busy periods, select and style changing
    doReq(1, 0, 10'h0F0, 6'b010101);
    doReq(0, 1, 10'h30C, 6'b110011);
    doReq(1, 1, 10'h001, 6'b011111);
    doReq(0, 0, 10'h200, 6'b100000);
    drain();
    report();
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    report();
  end

endmodule